// File: doc/BRIEF.md
# TCP Acknowledgement Receive Controller

This block is the data-phase receiver of a TCP server that holds one connection at a time. It stays idle until the connection manager starts it. Once started, it watches the header words that the IP layer delivers, one word per cycle. It throws away any segment that is not an acknowledgement, and any acknowledgement whose number differs from the one the transmit controller expects. When a matching acknowledgement arrives, it raises a one-cycle report toward the transmit controller and hands control over.

While it waits for control to come back, the receiver ignores all traffic. When the transmit controller returns control, the application's "no more data" indication decides the next step. If more data remains, the receiver listens for the next acknowledgement. If no data remains, it clears its local state and goes idle.

A segment is a burst of consecutive cycles with `seg_valid` high. The burst carries one 32-bit header word per cycle, in standard TCP header order. Only beats 2 and 3 matter to this block. Any beats after the header are skipped.

Top module: `tcp_ack_rx_ctrl`

## Requirements
- R1: During and after synchronous active-low reset, the block is idle: `rx_busy`=0, `ack_seen`=0 and `acked_num`=0.
- R2: In idle, segments have no effect and no report is made. A `rx_start` pulse in idle moves the block to listening, so `rx_busy` reads 1 from the next cycle onward.
- R3: Beats of a burst are counted from 0 and the count restarts whenever `seg_valid` is low. Beat 2 carries the acknowledgement number. Bit 20 of beat 3 is the ACK flag. A burst shorter than 4 beats is discarded.
- R4: A segment is accepted only if its ACK flag is 1 and its acknowledgement number equals `expect_ack` as sampled in the beat-3 cycle. Any other segment is discarded and `acked_num` keeps its value.
- R5: On acceptance, `ack_seen` is high for exactly one cycle, namely the cycle after beat 3. From that cycle on, `acked_num` holds the accepted number.
- R6: While waiting for control to return, incoming segments are ignored. No report is made and `acked_num` is held.
- R7: If `token_back` is high while `app_no_data` is 0, the block returns to listening and accepts the next matching acknowledgement.
- R8: If `token_back` is high while `app_no_data` is 1, the block goes idle: `rx_busy`=0 and `acked_num` is cleared to 0.
- R9: A burst whose beat 0 arrived while the block was not listening is never accepted, even if its later beats arrive after listening has begun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_start | input | 1 | Start request from the connection manager |
| seg_valid | input | 1 | High while a segment header word is present |
| seg_word | input | 32 | Current header word from the IP receive buffer |
| expect_ack | input | 32 | Next sequence number the transmit controller expects to be acknowledged |
| token_back | input | 1 | Transmit controller returns control |
| app_no_data | input | 1 | Application has no further data to send |
| ack_seen | output | 1 | One-cycle report of an accepted acknowledgement |
| acked_num | output | 32 | Number of the last accepted acknowledgement |
| rx_busy | output | 1 | High while listening or waiting for control |

## Verification
The in-RTL assertions check the following on every cycle. The beat count restarts between bursts. A burst begun outside listening never becomes owned. The report is a single cycle that lands only in the hand-over state, carrying the number that was expected. `acked_num` stays frozen during the hand-over. Going idle leaves the number cleared.

Some behaviours need whole scenarios in the bench. These are discarding by flag, discarding by number, and discarding by burst length. They also include the choice between listening again and going idle on return of control, and the late-start case where listening begins in the middle of a burst.

// File: rtl/tcp_ack_rx_pkg.sv
// Shared types and constants for the acknowledgement receive controller.
// Assumes header words arrive in standard TCP order, one word per beat.
package tcp_ack_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE    = 2'd0,
        RX_LISTEN  = 2'd1,
        RX_HANDOFF = 2'd2
    } rx_state_e;

    // Beat positions and flag bit that the parser depends on.
    localparam int ACK_BEAT_IDX  = 2;
    localparam int FLAG_BEAT_IDX = 3;
    localparam int ACK_FLAG_BIT  = 20;
endpackage

// File: rtl/seg_beat_counter.sv
// Counts the beats of the current burst and records whether the burst
// began while the controller was listening (burst ownership).
// Assumes a burst is a run of consecutive cycles with seg_valid high.
module seg_beat_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_valid,
    input  logic             listening,
    output logic [CNT_W-1:0] beat_idx,
    output logic             owned
);
    localparam logic [CNT_W-1:0] BEAT_MAX = {CNT_W{1'b1}};

    // Beat index: restarts between bursts, saturates on long bursts.
    always_ff @(posedge clk) begin
        if (!rst_n || !seg_valid) begin
            beat_idx <= '0;
        end else if (beat_idx != BEAT_MAX) begin
            beat_idx <= beat_idx + 1'b1;
        end
    end

    // Ownership: decided on beat 0, dropped when the burst ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !seg_valid) begin
            owned <= 1'b0;
        end else if (beat_idx == '0) begin
            owned <= listening;
        end
    end

    assert_beat_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !seg_valid |=> beat_idx == '0);

    assert_foreign_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && beat_idx == '0 && !listening) |=> !owned);
endmodule

// File: rtl/ack_field_capture.sv
// Captures the acknowledgement number from its header beat and judges the
// flag beat: ACK flag set and number equal to the expected value.
// Assumes the number beat precedes the flag beat within a burst.
module ack_field_capture #(
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 3,
    parameter int ACK_IDX  = 2,
    parameter int FLAG_IDX = 3,
    parameter int FLAG_BIT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_valid,
    input  logic [CNT_W-1:0]  beat_idx,
    input  logic [DATA_W-1:0] seg_word,
    input  logic [DATA_W-1:0] expect_ack,
    output logic [DATA_W-1:0] ack_num_q,
    output logic              flag_beat,
    output logic              ack_ok
);
    localparam logic [CNT_W-1:0] ACK_BEAT  = CNT_W'(ACK_IDX);
    localparam logic [CNT_W-1:0] FLAG_BEAT = CNT_W'(FLAG_IDX);

    // Number register: loaded on the acknowledgement-number beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_num_q <= '0;
        end else if (seg_valid && beat_idx == ACK_BEAT) begin
            ack_num_q <= seg_word;
        end
    end

    // Judgement: valid only in the flag-beat cycle.
    always_comb begin
        flag_beat = seg_valid && (beat_idx == FLAG_BEAT);
        ack_ok    = seg_word[FLAG_BIT] && (ack_num_q == expect_ack);
    end

    assert_number_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && beat_idx == ACK_BEAT) |=> ack_num_q == $past(seg_word));
endmodule

// File: rtl/tcp_ack_rx_ctrl.sv
// Acknowledgement receive controller for a single-connection TCP server.
// It idles until started, accepts matching ACK segments, reports each with
// a one-cycle pulse, waits for the transmit controller to return control,
// and then either listens again or clears its state and idles.
// Assumes the transmit controller holds expect_ack steady during a segment.
module tcp_ack_rx_ctrl
    import tcp_ack_rx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start,
    input  logic              seg_valid,
    input  logic [DATA_W-1:0] seg_word,
    input  logic [DATA_W-1:0] expect_ack,
    input  logic              token_back,
    input  logic              app_no_data,
    output logic              ack_seen,
    output logic [DATA_W-1:0] acked_num,
    output logic              rx_busy
);
    rx_state_e         state, state_nx;
    logic [CNT_W-1:0]  beat_idx;
    logic              owned;
    logic [DATA_W-1:0] ack_num_q;
    logic              flag_beat;
    logic              ack_ok;
    logic              accept;
    logic              go_idle;

    seg_beat_counter #(.CNT_W(CNT_W)) u_beats (
        .clk       (clk),
        .rst_n     (rst_n),
        .seg_valid (seg_valid),
        .listening (state == RX_LISTEN),
        .beat_idx  (beat_idx),
        .owned     (owned)
    );

    ack_field_capture #(
        .DATA_W   (DATA_W),
        .CNT_W    (CNT_W),
        .ACK_IDX  (ACK_BEAT_IDX),
        .FLAG_IDX (FLAG_BEAT_IDX),
        .FLAG_BIT (ACK_FLAG_BIT)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .seg_valid  (seg_valid),
        .beat_idx   (beat_idx),
        .seg_word   (seg_word),
        .expect_ack (expect_ack),
        .ack_num_q  (ack_num_q),
        .flag_beat  (flag_beat),
        .ack_ok     (ack_ok)
    );

    // Next-state logic for the idle / listen / hand-over cycle.
    always_comb begin
        accept   = (state == RX_LISTEN) && owned && flag_beat && ack_ok;
        go_idle  = (state == RX_HANDOFF) && token_back && app_no_data;
        state_nx = state;
        unique case (state)
            RX_IDLE:    if (rx_start) state_nx = RX_LISTEN;
            RX_LISTEN:  if (accept) state_nx = RX_HANDOFF;
            RX_HANDOFF: if (token_back) state_nx = app_no_data ? RX_IDLE : RX_LISTEN;
            default:    state_nx = RX_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    // Report pulse and accepted number; number cleared on going idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_seen  <= 1'b0;
            acked_num <= '0;
        end else begin
            ack_seen <= accept;
            if (accept)       acked_num <= ack_num_q;
            else if (go_idle) acked_num <= '0;
        end
    end

    assign rx_busy = (state != RX_IDLE);

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_seen |=> !ack_seen);

    assert_pulse_in_handoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_seen |-> (state == RX_HANDOFF && $past(state) == RX_LISTEN));

    assert_number_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_seen |-> (acked_num == $past(expect_ack) && $past(seg_word[ACK_FLAG_BIT])));

    assert_idle_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE) |-> !ack_seen);

    assert_handoff_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_HANDOFF && $past(state) == RX_HANDOFF) |-> $stable(acked_num));

    assert_idle_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && $past(state) == RX_HANDOFF) |-> acked_num == '0);
endmodule

// File: tb/tcp_ack_rx_ctrl_test.sv
module tcp_ack_rx_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_start = 1'b0;
    logic        seg_valid = 1'b0;
    logic [31:0] seg_word = '0;
    logic [31:0] expect_ack = '0;
    logic        token_back = 1'b0;
    logic        app_no_data = 1'b0;
    logic        ack_seen;
    logic [31:0] acked_num;
    logic        rx_busy;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    logic [31:0] model_num = '0;

    tcp_ack_rx_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .seg_valid(seg_valid),
        .seg_word(seg_word), .expect_ack(expect_ack), .token_back(token_back),
        .app_no_data(app_no_data), .ack_seen(ack_seen), .acked_num(acked_num),
        .rx_busy(rx_busy)
    );

    always #2 clk = ~clk;

    // Count report cycles, sampled away from the active edge.
    always @(negedge clk) if (ack_seen) pulses++;

    // Vector: {ack flag, number matches, beat count[2:0], accept expected}
    localparam logic [5:0] VECS [8] = '{
        {1'b1, 1'b1, 3'd4, 1'b1},
        {1'b0, 1'b1, 3'd4, 1'b0},
        {1'b1, 1'b0, 3'd4, 1'b0},
        {1'b1, 1'b1, 3'd3, 1'b0},
        {1'b1, 1'b1, 3'd6, 1'b1},
        {1'b0, 1'b0, 3'd5, 1'b0},
        {1'b1, 1'b1, 3'd5, 1'b1},
        {1'b1, 1'b1, 3'd2, 1'b0}
    };

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] beat_word(input int i, input logic flag, input logic [31:0] num);
        case (i)
            0: return 32'h1F90_C350;
            1: return 32'h0000_7777;
            2: return num;
            3: return flag ? 32'h5010_FFFF : 32'h5002_FFFF;
            default: return 32'hDEAD_0000 + 32'(i);
        endcase
    endfunction

    task automatic send_seg(input logic flag, input logic [31:0] num, input int beats);
        for (int i = 0; i < beats; i++) begin
            @(negedge clk);
            seg_valid = 1'b1;
            seg_word  = beat_word(i, flag, num);
        end
        @(negedge clk);
        seg_valid = 1'b0;
        seg_word  = '0;
        @(negedge clk);
        #1;
    endtask

    task automatic give_back(input logic no_data);
        @(negedge clk);
        token_back  = 1'b1;
        app_no_data = no_data;
        @(negedge clk);
        token_back  = 1'b0;
        app_no_data = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        finish_run();
    end

    initial begin
        int p0;
        logic [31:0] exp_num;
        repeat (3) @(negedge clk);
        #1;
        check(rx_busy == 1'b0 && ack_seen == 1'b0, "R1 idle/pulse", {30'd0, rx_busy, ack_seen}, 32'd0);
        check(acked_num == '0, "R1 number", acked_num, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: idle ignores a matching ACK
        expect_ack = 32'h0000_1234;
        p0 = pulses;
        send_seg(1'b1, 32'h0000_1234, 4);
        check(pulses == p0 && rx_busy == 1'b0, "R2 idle ignores", 32'(pulses - p0), 32'd0);

        // R2: start request
        @(negedge clk);
        rx_start = 1'b1;
        @(negedge clk);
        rx_start = 1'b0;
        #1;
        check(rx_busy == 1'b1, "R2 start", {31'd0, rx_busy}, 32'd1);

        // Table walk (R3, R4, R5, R7)
        for (int k = 0; k < 8; k++) begin
            exp_num    = 32'h1000_0000 + 32'(k * 16);
            expect_ack = exp_num;
            p0 = pulses;
            send_seg(VECS[k][5], VECS[k][4] ? exp_num : (exp_num ^ 32'h1), int'(VECS[k][3:1]));
            check((pulses - p0) == int'(VECS[k][0]), "R4/R3 accept decision", 32'(pulses - p0), {31'd0, VECS[k][0]});
            if (VECS[k][0]) begin
                model_num = exp_num;
                check(acked_num == model_num, "R5 number", acked_num, model_num);
                give_back(1'b0);
                check(rx_busy == 1'b1, "R7 listen again", {31'd0, rx_busy}, 32'd1);
            end else begin
                check(acked_num == model_num, "R4 number kept", acked_num, model_num);
            end
        end

        // R5: pulse exactly one cycle wide, right after beat 3
        expect_ack = 32'h2222_0000;
        p0 = pulses;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            seg_valid = 1'b1;
            seg_word  = beat_word(i, 1'b1, 32'h2222_0000);
        end
        @(negedge clk);
        #1;
        check(ack_seen == 1'b1, "R5 pulse timing", {31'd0, ack_seen}, 32'd1);
        seg_valid = 1'b0;
        @(negedge clk);
        #1;
        check(ack_seen == 1'b0 && pulses - p0 == 1, "R5 pulse width", 32'(pulses - p0), 32'd1);
        model_num = 32'h2222_0000;

        // R6: hand-over ignores another matching ACK
        expect_ack = 32'h3333_0000;
        p0 = pulses;
        send_seg(1'b1, 32'h3333_0000, 4);
        check(pulses == p0, "R6 no report", 32'(pulses - p0), 32'd0);
        check(acked_num == model_num, "R6 number held", acked_num, model_num);

        // R8: return with no data -> idle, cleared
        give_back(1'b1);
        check(rx_busy == 1'b0, "R8 idle", {31'd0, rx_busy}, 32'd0);
        check(acked_num == '0, "R8 cleared", acked_num, 32'd0);

        // R9: start arrives in the middle of a burst
        expect_ack = 32'h4444_0000;
        p0 = pulses;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            seg_valid = 1'b1;
            seg_word  = beat_word(i, 1'b1, 32'h4444_0000);
            rx_start  = (i == 1);
        end
        @(negedge clk);
        seg_valid = 1'b0;
        rx_start  = 1'b0;
        @(negedge clk);
        #1;
        check(pulses == p0 && rx_busy == 1'b1, "R9 foreign burst", 32'(pulses - p0), 32'd0);

        // R9/R7: next whole burst is accepted
        send_seg(1'b1, 32'h4444_0000, 4);
        check(pulses == p0 + 1 && acked_num == 32'h4444_0000, "R9 next accepted", acked_num, 32'h4444_0000);
        give_back(1'b1);
        check(rx_busy == 1'b0 && acked_num == '0, "R8 final idle", acked_num, 32'd0);

        finish_run();
    end
endmodule